// File: doc/BRIEF.md
# Decoded-Reload Binary Time-Base Divider

This block is a 14-stage binary counter that turns a slow square wave into one short pulse every fixed number of input periods. Each falling edge of the input clock advances the count. A sparse decode watches for a terminal count. Only the counter bits that are set in that count are ANDed together, with no full magnitude comparator. When the decode hits, the counter reloads to zero and a one-period pulse is raised. With the default terminal count of 3600 and a 60 Hz input, the pulse repeats once a minute.

The counter is a single synchronous register, and the pulse comes from a flop. No output can therefore show the decoding spikes that a ripple chain produces. Twelve stages can be seen on the tap bus: stage 1 and stages 4 through 14. Stages 2 and 3 stay inside the block.

An active-high clear forces every stage and the pulse low at once, without waiting for a clock edge. The clear is released through a short falling-edge synchroniser, so the first counted edge after the clear drops is always the same edge.

Top module: `pulse_timebase`

## Requirements
- R1: While `clr_i` is high, `tap_o` is all zeros and `tick_o` is 0. This takes effect as soon as clear rises, with no clock edge needed.
- R2: After `clr_i` falls, the next two falling edges of `clk_i` leave the count at 0. The third falling edge takes the count to 1.
- R3: While the block is out of clear, each falling edge of `clk_i` adds one to the count. Rising edges leave every output unchanged.
- R4: Tap mapping. `tap_o[0]` is count bit 0 (stage 1), so it toggles on every counted falling edge. For k from 1 to 11, `tap_o[k]` is count bit k+2 (stage k+3).
- R5: The count only takes values from 0 to TERM-1. With the default TERM of 3600, `tap_o[11]` and `tap_o[10]` (stages 14 and 13) never go high.
- R6: On the falling edge where the count is TERM-1, the count goes to 0 and `tick_o` rises. `tick_o` stays high for exactly one clock period.
- R7: Outside of clear, consecutive rising transitions of `tick_o` are exactly TERM falling edges apart.
- R8: The terminal decode looks only at the bits that are set in TERM. With the default TERM these are stages 5, 10, 11 and 12. That pattern never appears at any count below TERM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input square wave; the count advances on its falling edge |
| clr_i | input | 1 | Asynchronous active-high clear |
| tap_o | output | 12 | Counter stages 1 and 4 to 14, with stage 1 in bit 0 |
| tick_o | output | 1 | Terminal pulse, one clock period long |

## Verification
The assertions are checked on every falling edge: the count steps by one, it wraps from TERM-1 to zero together with the pulse, the pulse never lasts two periods, and the count stays below TERM. They also check that the outputs are zero whenever clear is high. Some behaviour can only be shown by the bench's scenarios. These are the exact length of the two-edge release after clear and the tap-to-stage mapping seen at the pins. The bench also measures the spacing between pulses across several full periods and checks that clear pulses arriving in the middle of a clock cycle take effect at once.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  // Stage index (0-based count bit) carried by tap position k.
  // Position 0 holds stage 1; positions 1.. skip the two hidden stages.
  function automatic int tap_stage(input int k);
    return (k == 0) ? 0 : k + 2;
  endfunction
endpackage

// File: rtl/tb_release_sync.sv
module tb_release_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic clr_i,
  output logic hold_o
);
  logic [DEPTH-1:0] pipe_q;

  // Asserts at once with clear; drops only after DEPTH falling edges.
  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i) pipe_q <= '1;
    else       pipe_q <= {pipe_q[DEPTH-2:0], 1'b0};
  end

  assign hold_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/tb_count_core.sv
module tb_count_core #(
  parameter int STAGES = 14,
  parameter int TERM   = 3600
) (
  input  logic              clk_i,
  input  logic              hold_i,
  output logic [STAGES-1:0] cnt_o,
  output logic              tick_o
);
  localparam logic [STAGES-1:0] MASK = STAGES'(TERM);

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] nxt;
  logic [STAGES-1:0] hit_bits;
  logic              hit;
  logic              tick_q;

  assign nxt = cnt_q + 1'b1;

  // Sparse decode: only the bits set in TERM take part in the AND.
  for (genvar i = 0; i < STAGES; i++) begin : g_dec
    if (MASK[i]) begin : g_use
      assign hit_bits[i] = nxt[i];
    end else begin : g_skip
      assign hit_bits[i] = 1'b1;
    end
  end
  assign hit = &hit_bits;

  always_ff @(negedge clk_i or posedge hold_i) begin
    if (hold_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (hit) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= nxt;
      tick_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/tb_tap_map.sv
module tb_tap_map
  import timebase_pkg::*;
#(
  parameter int STAGES = 14,
  localparam int TAPS = STAGES - 2
) (
  input  logic [STAGES-1:0] cnt_i,
  output logic [TAPS-1:0]   tap_o
);
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_o[k] = cnt_i[tap_stage(k)];
  end

  logic unused_hidden;
  assign unused_hidden = ^cnt_i[2:1];
endmodule

// File: rtl/pulse_timebase.sv
module pulse_timebase #(
  parameter int STAGES     = 14,
  parameter int TERM       = 3600,
  parameter int SYNC_DEPTH = 2,
  localparam int TAPS = STAGES - 2
) (
  input  logic            clk_i,
  input  logic            clr_i,
  output logic [TAPS-1:0] tap_o,
  output logic            tick_o
);
  logic              hold_q;
  logic [STAGES-1:0] cnt_q;

  tb_release_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .clr_i  (clr_i),
    .hold_o (hold_q)
  );

  tb_count_core #(.STAGES(STAGES), .TERM(TERM)) u_core (
    .clk_i  (clk_i),
    .hold_i (hold_q),
    .cnt_o  (cnt_q),
    .tick_o (tick_o)
  );

  tb_tap_map #(.STAGES(STAGES)) u_map (
    .cnt_i (cnt_q),
    .tap_o (tap_o)
  );
endmodule

// File: rtl/timebase_chk.sv
module timebase_chk #(
  parameter int STAGES = 14,
  parameter int TERM   = 3600,
  localparam int TAPS = STAGES - 2
) (
  input logic              clk_i,
  input logic              clr_i,
  input logic              hold,
  input logic [STAGES-1:0] cnt,
  input logic [TAPS-1:0]   tap_o,
  input logic              tick_o
);
  localparam logic [STAGES-1:0] LAST = STAGES'(TERM - 1);

  // R1: clear forces every visible output low
  a_r1_clear_zero: assert property (@(posedge clk_i)
    clr_i |-> (tap_o == '0 && !tick_o));

  // R3: plain increment below the terminal count
  a_r3_step: assert property (@(negedge clk_i) disable iff (hold)
    (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1 && !tick_o));

  // R6: wrap to zero together with the pulse
  a_r6_wrap: assert property (@(negedge clk_i) disable iff (hold)
    (cnt == LAST) |=> (cnt == '0 && tick_o));

  // R6: pulse lasts one period only
  a_r6_tick_single: assert property (@(negedge clk_i) disable iff (hold)
    tick_o |=> !tick_o);

  // R5 / R8: count never reaches or passes the decoded pattern
  a_r5_range: assert property (@(negedge clk_i) disable iff (hold)
    cnt < STAGES'(TERM));
endmodule

bind pulse_timebase timebase_chk #(.STAGES(STAGES), .TERM(TERM)) u_chk (
  .clk_i  (clk_i),
  .clr_i  (clr_i),
  .hold   (hold_q),
  .cnt    (cnt_q),
  .tap_o  (tap_o),
  .tick_o (tick_o)
);

// File: tb/sim_pulse_timebase.sv
`timescale 1ns/100ps
module sim_pulse_timebase;
  localparam int STAGES = 14;
  localparam int TERM   = 3600;
  localparam int TAPS   = STAGES - 2;

  logic            clk = 1'b1;
  logic            clr = 1'b1;
  logic [TAPS-1:0] tap;
  logic            tick;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit exp_tick = 0;
  int hold_left = 2;
  int gap = 0;
  bit gap_valid = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_timebase u0 (.clk_i(clk), .clr_i(clr), .tap_o(tap), .tick_o(tick));

  // R4: expected tap bus from a count value
  function automatic logic [TAPS-1:0] taps_of(input int c);
    logic [TAPS-1:0] t;
    t[0] = c[0];
    for (int k = 1; k < TAPS; k++) t[k] = c[k+2];
    return t;
  endfunction

  task automatic check(input string req, input logic [TAPS-1:0] t_exp, input bit k_exp);
    checks++;
    if (tap !== t_exp || tick !== k_exp) begin
      errors++;
      $display("FAIL %s tap=%h tick=%b expected tap=%h tick=%b", req, tap, tick, t_exp, k_exp);
    end
  endtask

  // Model one falling edge, then compare 1 ns later.
  task automatic edge_step(input string req);
    @(negedge clk);
    if (clr) begin
      exp_cnt = 0; exp_tick = 0; hold_left = 2; gap_valid = 0;
    end else if (hold_left > 0) begin
      hold_left--; exp_cnt = 0; exp_tick = 0;   // R2
    end else if (exp_cnt + 1 == TERM) begin
      exp_cnt = 0; exp_tick = 1;                // R6
    end else begin
      exp_cnt++; exp_tick = 0;                  // R3
    end
    gap++;
    #1;
    check(req, taps_of(exp_cnt), exp_tick);
    if (tick === 1'b1) begin
      if (gap_valid) begin                      // R7
        checks++;
        if (gap != TERM) begin
          errors++;
          $display("FAIL R7 gap=%0d expected %0d", gap, TERM);
        end
      end
      gap_valid = 1; gap = 0;
    end
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) edge_step(req);
  endtask

  // R1: assert clear mid-cycle and look at once
  task automatic pulse_clear(input int periods);
    @(posedge clk); #0.5;
    clr = 1'b1;
    #0.5;
    check("R1", '0, 1'b0);
    run(periods, "R1");
    @(posedge clk); #0.5;
    clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4021));
    #1;
    check("R1", '0, 1'b0);                      // reset state
    run(2, "R1");
    @(posedge clk); #0.5; clr = 1'b0;
    run(2, "R2");                               // held at zero
    run(1, "R2");                               // first count
    checks++;
    if (tap[0] !== 1'b1) begin errors++; $display("FAIL R2 tap0=%b expected 1", tap[0]); end
    // R3: rising edge leaves outputs alone
    @(posedge clk); #1;
    check("R3", taps_of(exp_cnt), exp_tick);
    run(40, "R4");
    // R5 R6 R7 R8: several full periods
    run(3 * TERM + 20, "R6");
    checks++;
    if (gap_valid !== 1'b1) begin errors++; $display("FAIL R7 no tick seen, expected one"); end
    // Random mix of runs and mid-run clears
    for (int it = 0; it < 8; it++) begin
      run($urandom_range(30, 2500), "R3");
      if ($urandom_range(0, 1) == 1) pulse_clear($urandom_range(1, 3));
    end
    // Corner: clear right after a tick, then straight into a wrap
    run(TERM + 5, "R6");
    pulse_clear(1);
    run(TERM + 10, "R7");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule